// File: doc/BRIEF.md
# Pipelined Reversible Gate Unit

This unit applies one of five three-line reversible gates to a 3-bit vector: controlled-NOT, Toffoli, Fredkin, SWAP and Peres. The caller picks the gate with a 3-bit code. Every gate function is built from a single reversible majority primitive with three outputs. With its first input tied to 0, that primitive yields the AND of the other two inputs on its first output and their OR on its second output. XOR, multiplexing and exchange are all composed from those two terms.

Each gate returns its result after its own fixed number of register stages. The gate code travels with the result. The unit accepts one operation per cycle. If a new operation would complete in the same cycle as one already in flight, the unit drops `inReady` and the caller holds the request. As a result, at most one result leaves the unit per cycle, in a fixed order.

Bit 0 of the input vector is line A, bit 1 is line B and bit 2 is line C. The output bits follow the same order, called P, Q and R.

Top module: `revGateUnit`

## Requirements
- R1: Code 3'd0 (controlled-NOT) gives P = A, Q = A XOR B and R = C. The result appears 3 register stages after acceptance: accepted at edge k, `outValid` is high in the cycle after edge k+2.
- R2: Code 3'd1 (Toffoli) gives P = A, Q = B and R = (A AND B) XOR C, with a latency of 5 stages.
- R3: Code 3'd2 (Fredkin) gives P = A. When A = 1, Q = C and R = B; when A = 0, B and C pass through unchanged. Latency is 5 stages.
- R4: Code 3'd3 (SWAP) gives P = B, Q = A and R = C, with a latency of 9 stages. A SWAP request is never held off.
- R5: Code 3'd4 (Peres) gives P = A, Q = A XOR B and R = (A AND B) XOR C, with a latency of 5 stages.
- R6: Codes 3'd5, 3'd6 and 3'd7 return the input vector unchanged after 1 stage.
- R7: `outGate` carries the code that was accepted with the operation whose result is on `outData`.
- R8: An operation is accepted on any edge where `inValid` and `inReady` are both high, so back-to-back issue gives one accept per cycle. `inReady` is low exactly when the requested gate's completion cycle is already taken. A held request is accepted, unaltered, on the first edge where that cycle is free.
- R9: Each accepted operation produces exactly one `outValid` pulse. Results leave the unit in order of completion cycle.
- R10: A synchronous active-high `rst` discards every operation in flight. While `rst` is high and after it is released, `outValid` is low until a new operation completes, and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe |
| inGate | input | 3 | Gate select code |
| inData | input | 3 | Input lines {C,B,A} |
| inReady | output | 1 | Request can be accepted this cycle |
| outValid | output | 1 | Result present |
| outGate | output | 3 | Gate code of the result |
| outData | output | 3 | Output lines {R,Q,P} |

## Verification
Two operations of different latency can be due in the same cycle. The bench provokes this with a Toffoli request followed two cycles later by a controlled-NOT request, whose 3-stage path would land on the Toffoli result. It checks that `inReady` is low for that cycle and high on the next one. It then checks that both results come out in consecutive cycles, with the Toffoli result first and both values and gate codes intact. A burst of four controlled-NOT requests confirms that requests on a free path are never held.

// File: rtl/revGatePkg.sv
package revGatePkg;
  localparam int DATA_W    = 3;
  localparam int CODE_W    = 3;
  localparam int LAT_CNOT  = 3;
  localparam int LAT_CCNOT = 5;
  localparam int LAT_FRED  = 5;
  localparam int LAT_SWAP  = 9;
  localparam int LAT_PERES = 5;
  localparam int LAT_PASS  = 1;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int MAX_LAT = maxOf(maxOf(maxOf(LAT_CNOT, LAT_CCNOT), maxOf(LAT_FRED, LAT_SWAP)),
                                 maxOf(LAT_PERES, LAT_PASS));
  localparam int IDX_W   = (MAX_LAT > 1) ? $clog2(MAX_LAT) : 1;

  typedef enum logic [CODE_W-1:0] {
    G_CNOT  = 3'd0,
    G_CCNOT = 3'd1,
    G_FRED  = 3'd2,
    G_SWAP  = 3'd3,
    G_PERES = 3'd4
  } gateSel_e;

  typedef struct packed {
    logic               accept;
    logic [MAX_LAT-1:0] loadSlot;
  } ctrlStrobe_t;

  function automatic int latOf(input logic [CODE_W-1:0] code);
    case (code)
      G_CNOT:  return LAT_CNOT;
      G_CCNOT: return LAT_CCNOT;
      G_FRED:  return LAT_FRED;
      G_SWAP:  return LAT_SWAP;
      G_PERES: return LAT_PERES;
      default: return LAT_PASS;
    endcase
  endfunction

  function automatic logic maj(input logic x, input logic y, input logic z);
    return (x & y) | (y & z) | (x & z);
  endfunction

  // three-output reversible majority primitive, returned as {Z,Y,X}
  function automatic logic [2:0] majPrim(input logic x, input logic y, input logic z);
    return {maj(x, ~y, z), maj(~x, y, z), maj(x, y, z)};
  endfunction

  function automatic logic revAnd(input logic p, input logic q);
    logic [2:0] t;
    t = majPrim(1'b0, p, q);
    return t[0];
  endfunction

  function automatic logic revOr(input logic p, input logic q);
    logic [2:0] t;
    t = majPrim(1'b0, p, q);
    return t[1];
  endfunction

  function automatic logic revXor(input logic p, input logic q);
    return revOr(revAnd(p, ~q), revAnd(~p, q));
  endfunction
endpackage

// File: rtl/revGateLogic.sv
module revGateLogic
  import revGatePkg::*;
(
  input  logic [CODE_W-1:0] gateCode,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  logic a, b, c;
  logic sw1, sw2, sw3;

  assign a = din[0];
  assign b = din[1];
  assign c = din[2];

  // swap as three chained controlled-NOT stages
  assign sw1 = revXor(a, b);
  assign sw2 = revXor(a, sw1);
  assign sw3 = revXor(sw2, sw1);

  always_comb begin
    case (gateCode)
      G_CNOT:  dout = {c, revXor(a, b), a};
      G_CCNOT: dout = {revXor(revAnd(a, b), c), b, a};
      G_FRED:  dout = {revOr(revAnd(~a, c), revAnd(a, b)),
                       revOr(revAnd(~a, b), revAnd(a, c)), a};
      G_SWAP:  dout = {c, sw3, sw2};
      G_PERES: dout = {revXor(revAnd(a, b), c), revXor(a, b), a};
      default: dout = din;
    endcase
  end
endmodule

// File: rtl/revGateCtrl.sv
module revGateCtrl
  import revGatePkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [CODE_W-1:0] inGate,
  output logic              inReady,
  output logic              outValid,
  output ctrlStrobe_t       strobe
);
  logic [MAX_LAT-1:0] busy;
  int                 lat;
  logic               slotTaken;

  always_comb begin
    lat       = latOf(inGate);
    slotTaken = (lat < MAX_LAT) ? busy[IDX_W'(lat)] : 1'b0;
    inReady   = !slotTaken;
    strobe.accept   = inValid && inReady;
    strobe.loadSlot = strobe.accept ? (MAX_LAT'(1) << (lat - 1)) : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= (busy >> 1) | strobe.loadSlot;
  end

  assign outValid = busy[0];
endmodule

// File: rtl/revGateDatapath.sv
module revGateDatapath
  import revGatePkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [CODE_W-1:0] inGate,
  input  logic [DATA_W-1:0] inData,
  output logic [CODE_W-1:0] outGate,
  output logic [DATA_W-1:0] outData
);
  localparam int ENTRY_W = CODE_W + DATA_W;

  logic [DATA_W-1:0]  gateOut;
  logic [ENTRY_W-1:0] slotQ [MAX_LAT];

  revGateLogic uLogic (
    .gateCode(inGate),
    .din     (inData),
    .dout    (gateOut)
  );

  for (genvar i = 0; i < MAX_LAT; i++) begin : gSlot
    logic [ENTRY_W-1:0] shiftIn;
    if (i == MAX_LAT - 1) begin : gTop
      assign shiftIn = '0;
    end else begin : gMid
      assign shiftIn = slotQ[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)                    slotQ[i] <= '0;
      else if (strobe.loadSlot[i]) slotQ[i] <= {inGate, gateOut};
      else                        slotQ[i] <= shiftIn;
    end
  end

  assign outGate = slotQ[0][ENTRY_W-1:DATA_W];
  assign outData = slotQ[0][DATA_W-1:0];
endmodule

// File: rtl/revGateUnit.sv
module revGateUnit
  import revGatePkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [CODE_W-1:0] inGate,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              outValid,
  output logic [CODE_W-1:0] outGate,
  output logic [DATA_W-1:0] outData
);
  ctrlStrobe_t strobe;

  revGateCtrl uCtrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inGate  (inGate),
    .inReady (inReady),
    .outValid(outValid),
    .strobe  (strobe)
  );

  revGateDatapath uPath (
    .clk    (clk),
    .rst    (rst),
    .strobe (strobe),
    .inGate (inGate),
    .inData (inData),
    .outGate(outGate),
    .outData(outData)
  );
endmodule

// File: rtl/revGateUnitChk.sv
module revGateUnitChk (
  input logic       clk,
  input logic       rst,
  input logic       inValid,
  input logic [2:0] inGate,
  input logic [2:0] inData,
  input logic       inReady,
  input logic       outValid,
  input logic [2:0] outGate,
  input logic [2:0] outData
);
  logic take;
  assign take = inValid && inReady;

  p_cnot_result_r1: assert property (@(posedge clk) disable iff (rst)
    take && inGate == 3'd0 |=> ##2 outValid && outGate == 3'd0 &&
      outData == {$past(inData[2], 3), $past(inData[0] ^ inData[1], 3), $past(inData[0], 3)});

  p_ccnot_result_r2: assert property (@(posedge clk) disable iff (rst)
    take && inGate == 3'd1 |=> ##4 outValid && outGate == 3'd1 &&
      outData == {$past((inData[0] & inData[1]) ^ inData[2], 5), $past(inData[1:0], 5)});

  p_swap_result_r4: assert property (@(posedge clk) disable iff (rst)
    take && inGate == 3'd3 |=> ##8 outValid && outGate == 3'd3 &&
      outData == {$past(inData[2], 9), $past(inData[0], 9), $past(inData[1], 9)});

  p_swap_ready_r4: assert property (@(posedge clk) disable iff (rst)
    inGate == 3'd3 |-> inReady);

  p_pass_result_r6: assert property (@(posedge clk) disable iff (rst)
    take && inGate > 3'd4 |=> outValid && outGate == $past(inGate) && outData == $past(inData));

  p_reset_clear_r10: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !outValid && inReady);
endmodule

bind revGateUnit revGateUnitChk uChk (
  .clk     (clk),
  .rst     (rst),
  .inValid (inValid),
  .inGate  (inGate),
  .inData  (inData),
  .inReady (inReady),
  .outValid(outValid),
  .outGate (outGate),
  .outData (outData)
);

// File: tb/sim_revGateUnit.sv
`timescale 1ns/1ps
module sim_revGateUnit;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [2:0] inGate = 3'd0;
  logic [2:0] inData = 3'd0;
  logic       inReady, outValid;
  logic [2:0] outGate, outData;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int logCnt = 0;
  logic [2:0] logData [64];
  logic [2:0] logGate [64];
  int         logCyc  [64];

  always #2 clk = ~clk;

  revGateUnit u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inGate(inGate), .inData(inData),
    .inReady(inReady), .outValid(outValid), .outGate(outGate), .outData(outData)
  );

  // result log sampled at the edge, before the edge's updates land
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (outValid && logCnt < 64) begin
      logData[logCnt] = outData;
      logGate[logCnt] = outGate;
      logCyc[logCnt]  = cyc;
      logCnt = logCnt + 1;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic string reqOf(input logic [2:0] g);
    case (g)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  // {gate, input {C,B,A}, expected {R,Q,P}, latency}
  localparam int NVEC = 17;
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd0, 3'b010, 3'b010, 4'd3}, {3'd0, 3'b011, 3'b001, 4'd3}, {3'd0, 3'b101, 3'b111, 4'd3},
    {3'd1, 3'b011, 3'b111, 4'd5}, {3'd1, 3'b111, 3'b011, 4'd5}, {3'd1, 3'b101, 3'b101, 4'd5},
    {3'd2, 3'b011, 3'b101, 4'd5}, {3'd2, 3'b010, 3'b010, 4'd5}, {3'd2, 3'b101, 3'b011, 4'd5},
    {3'd3, 3'b001, 3'b010, 4'd9}, {3'd3, 3'b110, 3'b101, 4'd9}, {3'd3, 3'b100, 3'b100, 4'd9},
    {3'd4, 3'b011, 3'b101, 4'd5}, {3'd4, 3'b111, 3'b001, 4'd5}, {3'd4, 3'b001, 3'b011, 4'd5},
    {3'd5, 3'b110, 3'b110, 4'd1}, {3'd7, 3'b011, 3'b011, 4'd1}
  };

  task automatic runOne(input logic [2:0] g, input logic [2:0] d, input logic [2:0] e, input int lat);
    int n;
    @(negedge clk);
    inValid = 1'b1; inGate = g; inData = d;
    #0.5;
    check(inReady, "R8", int'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    n = 1;
    while (!outValid && n < 20) begin
      @(negedge clk);
      n++;
    end
    check(n == lat, reqOf(g), n, lat);
    check(outData == e, reqOf(g), int'(outData), int'(e));
    check(outGate == g, "R7", int'(outGate), int'(g));
    @(negedge clk);
    check(!outValid, "R9", int'(outValid), 0);
  endtask

  initial begin
    int start;
    repeat (3) @(negedge clk);
    check(!outValid, "R10", int'(outValid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!outValid, "R10", int'(outValid), 0);
    check(inReady, "R10", int'(inReady), 1);

    for (int i = 0; i < NVEC; i++)
      runOne(VEC[i][12:10], VEC[i][9:7], VEC[i][6:4], int'(VEC[i][3:0]));

    // R8: back-to-back controlled-NOT burst
    @(negedge clk);
    start = logCnt;
    for (int i = 0; i < 4; i++) begin
      inValid = 1'b1; inGate = 3'd0; inData = 3'(i);
      #0.5;
      check(inReady, "R8", int'(inReady), 1);
      @(negedge clk);
    end
    inValid = 1'b0;
    repeat (10) @(negedge clk);
    check(logCnt - start == 4, "R8", logCnt - start, 4);
    if (logCnt - start == 4) begin
      check(logData[start] == 3'b000, "R1", int'(logData[start]), 0);
      check(logData[start+1] == 3'b011, "R1", int'(logData[start+1]), 3);
      check(logData[start+2] == 3'b010, "R1", int'(logData[start+2]), 2);
      check(logData[start+3] == 3'b001, "R1", int'(logData[start+3]), 1);
      check(logCyc[start+3] - logCyc[start] == 3, "R9", logCyc[start+3] - logCyc[start], 3);
    end

    // R8/R9: completion collision between Toffoli and controlled-NOT
    start = logCnt;
    inValid = 1'b1; inGate = 3'd1; inData = 3'b011;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    inValid = 1'b1; inGate = 3'd0; inData = 3'b001;
    #0.5;
    check(!inReady, "R8", int'(inReady), 0);
    @(negedge clk);
    #0.5;
    check(inReady, "R8", int'(inReady), 1);
    @(negedge clk);
    inValid = 1'b0;
    repeat (10) @(negedge clk);
    check(logCnt - start == 2, "R9", logCnt - start, 2);
    if (logCnt - start == 2) begin
      check(logGate[start] == 3'd1, "R9", int'(logGate[start]), 1);
      check(logData[start] == 3'b111, "R2", int'(logData[start]), 7);
      check(logGate[start+1] == 3'd0, "R9", int'(logGate[start+1]), 0);
      check(logData[start+1] == 3'b011, "R8", int'(logData[start+1]), 3);
      check(logCyc[start+1] - logCyc[start] == 1, "R9", logCyc[start+1] - logCyc[start], 1);
    end

    // R10: reset drops an in-flight SWAP
    inValid = 1'b1; inGate = 3'd3; inData = 3'b001;
    @(negedge clk);
    inValid = 1'b0;
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    start = logCnt;
    check(inReady, "R10", int'(inReady), 1);
    repeat (12) @(negedge clk);
    check(logCnt == start, "R10", logCnt - start, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule